// File: doc/BRIEF.md
# Bouncing Scrolling Decimal Digit Display

This block runs a single decimal digit on a bank of eight common-cathode seven-segment displays. Each rising clock edge advances the digit value by one, from 0 to 9 and back to 0. On the same edge, the lit display moves one place. It sweeps from the rightmost digit out to the leftmost and then back again. Neither end is repeated, so one full sweep takes fourteen clocks.

The value and the position run in lockstep from a common reset. The segment bus and the binary digit select can be wired directly to a multiplexed display bank. Any slowing of the clock to a visible rate is done outside the block. The bank size and the counting modulus are parameters. The defaults are eight digits and modulus ten.

Top module: `scroll_digit_disp`

## Requirements
- R1: While rst_n is low, seg_o shows the glyph for 0 (8'hFC) and sel_o is 3'b111 (the rightmost digit).
- R2: The digit value advances by one on every rising clock edge out of reset, and after 9 it returns to 0.
- R3: seg_o bit 7 drives segment a, bits 6 down to 1 drive b, c, d, e, f, g, and bit 0 drives dp. A 1 lights a segment. The glyphs for 0 to 9 are FC, 60, DA, F2, 66, B6, BE, E0, FE, F6 (hex).
- R4: seg_o bit 0 (dp) is always 0 outside reset.
- R5: sel_o is a binary code in which 111 selects digit 1 (rightmost), 110 digit 2, and so on down to 000 for digit 8 (leftmost).
- R6: The position steps through 14 states and then wraps. States 0 to 7 light digits 1 to 8 in order, and states 8 to 13 light digits 7 down to 2. The sel_o sequence from reset is therefore 7,6,5,4,3,2,1,0,1,2,3,4,5,6, then repeats.
- R7: On every clock out of reset, sel_o changes by exactly one. An end digit (sel_o 000 or 111) is never lit on two consecutive clocks.
- R8: Clock edges while rst_n is low leave seg_o and sel_o at their reset values. After release, the first edge gives the value 1 at the second digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; both the value and the position advance on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| seg_o | output | 8 | Segment lines a..g, dp (bit 7 = a, bit 0 = dp), active high |
| sel_o | output | 3 | Binary digit select, 111 = rightmost, 000 = leftmost |

## Verification
The bench builds the block with its defaults: eight digits and modulus ten. This makes the lit position cycle in 14 steps while the value cycles in 10 steps. The two cycles realign only every 70 clocks. A run of 150 clocks therefore covers every pairing of value and position, with both sweep ends and the value wrap reached several times. Reset is also asserted in the middle of a sweep, which shows that both sequences restart together from the rightmost digit.

// File: rtl/disp_pkg.sv
package disp_pkg;

  localparam int SEG_W = 8;

  // Segment order: bit 7 = a ... bit 1 = g, bit 0 = dp; high lights.
  function automatic logic [SEG_W-1:0] digit_glyph(input logic [3:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'd0:    g = 8'hFC;
      4'd1:    g = 8'h60;
      4'd2:    g = 8'hDA;
      4'd3:    g = 8'hF2;
      4'd4:    g = 8'h66;
      4'd5:    g = 8'hB6;
      4'd6:    g = 8'hBE;
      4'd7:    g = 8'hE0;
      4'd8:    g = 8'hFE;
      4'd9:    g = 8'hF6;
      default: g = 8'h00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mod_counter.sv
module mod_counter #(
  parameter int MODULUS = 10,
  localparam int W = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == TOP) cnt_d = '0;
      else              cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: wrap after the last value
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == TOP) |=> (cnt_q == '0));

  // R2: single step otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + W'(1)));

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/bounce_seq.sv
module bounce_seq #(
  parameter int NUM_DIGITS = 8,
  localparam int STEPS   = 2 * NUM_DIGITS - 2,
  localparam int STATE_W = $clog2(STEPS),
  localparam int SEL_W   = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [SEL_W-1:0] sel_o
);

  localparam logic [STATE_W-1:0] LAST_STATE = STATE_W'(STEPS - 1);
  localparam logic [STATE_W-1:0] FAR_END    = STATE_W'(NUM_DIGITS - 1);

  logic [STATE_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (en) begin
      if (st_q == LAST_STATE) st_d = '0;
      else                    st_d = st_q + STATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  // Outbound half: digit index = state; return half mirrors it.
  always_comb begin
    if (st_q <= FAR_END) sel_o = SEL_W'(FAR_END - st_q);
    else                 sel_o = SEL_W'(st_q - FAR_END);
  end

  // R6: the sequence closes after STEPS states
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == LAST_STATE) |=> (st_q == '0));

  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= LAST_STATE);

endmodule

// File: rtl/seg_glyph.sv
module seg_glyph
  import disp_pkg::*;
#(
  parameter int VAL_W = 4
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [SEG_W-1:0] seg_o
);

  logic [3:0] v4;

  generate
    if (VAL_W >= 4) begin : g_trunc
      assign v4 = val_i[3:0];
    end else begin : g_pad
      assign v4 = {{(4-VAL_W){1'b0}}, val_i};
    end
  endgenerate

  always_comb seg_o = digit_glyph(v4);

endmodule

// File: rtl/scroll_digit_disp.sv
module scroll_digit_disp
  import disp_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int MODULUS    = 10,
  localparam int SEL_W = $clog2(NUM_DIGITS),
  localparam int VAL_W = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEG_W-1:0] seg_o,
  output logic [SEL_W-1:0] sel_o
);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_DIGITS - 1);

  logic             step_en;
  logic [VAL_W-1:0] val;

  assign step_en = 1'b1;

  mod_counter #(.MODULUS(MODULUS)) u_val (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step_en),
    .cnt_o (val)
  );

  bounce_seq #(.NUM_DIGITS(NUM_DIGITS)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step_en),
    .sel_o (sel_o)
  );

  seg_glyph #(.VAL_W(VAL_W)) u_glyph (
    .val_i (val),
    .seg_o (seg_o)
  );

  // R4: decimal point never lit
  a_r4_dp_off: assert property (@(posedge clk) disable iff (!rst_n)
    seg_o[0] == 1'b0);

  // R7: the lit digit moves by exactly one place per clock
  a_r7_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((SEL_W'(sel_o - $past(sel_o)) == SEL_W'(1)) ||
              (SEL_W'($past(sel_o) - sel_o) == SEL_W'(1))));

  // R7: bounce at the leftmost end
  a_r7_left_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == '0) |=> (sel_o == SEL_W'(1)));

  // R7: bounce at the rightmost end
  a_r7_right_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == SEL_MAX) |=> (sel_o == SEL_MAX - SEL_W'(1)));

endmodule

// File: tb/scroll_digit_disp_tb_top.sv
module scroll_digit_disp_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] seg_o;
  logic [2:0] sel_o;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [7:0] GLYPH [10] = '{8'hFC, 8'h60, 8'hDA, 8'hF2, 8'h66,
                                        8'hB6, 8'hBE, 8'hE0, 8'hFE, 8'hF6};
  localparam logic [2:0] SELT [14] = '{3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1,
                                       3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};

  scroll_digit_disp dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .seg_o (seg_o),
    .sel_o (sel_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [2:0] prev_sel;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset seg", int'(seg_o), 8'hFC);
    check("R1 reset sel", int'(sel_o), 3'b111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 held reset seg", int'(seg_o), 8'hFC);
    check("R8 held reset sel", int'(sel_o), 3'b111);
    rst_n = 1'b1;
    prev_sel = sel_o;

    // Table walk: value and position over 150 clocks
    for (int k = 1; k <= 150; k++) begin
      @(posedge clk);
      @(negedge clk);
      check((k % 10 == 0) ? "R2 value wrap" : "R3 glyph", int'(seg_o), int'(GLYPH[k % 10]));
      check((k % 14 == 0) ? "R6 position wrap" : "R5 select", int'(sel_o), int'(SELT[k % 14]));
      check("R4 dp off", int'(seg_o[0]), 0);
      check("R7 one step",
            ((int'(sel_o) - int'(prev_sel) == 1) || (int'(prev_sel) - int'(sel_o) == 1)) ? 1 : 0, 1);
      prev_sel = sel_o;
    end

    // Mid-sweep reset: both sequences restart together
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset seg", int'(seg_o), 8'hFC);
    check("R1 async reset sel", int'(sel_o), 3'b111);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 clocks ignored seg", int'(seg_o), 8'hFC);
    check("R8 clocks ignored sel", int'(sel_o), 3'b111);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 first step seg", int'(seg_o), 8'h60);
    check("R8 first step sel", int'(sel_o), 3'b110);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R5 leftmost reached", int'(sel_o), 3'b000);
    check("R3 glyph seven", int'(seg_o), 8'hE0);
    @(posedge clk);
    @(negedge clk);
    check("R7 left bounce", int'(sel_o), 3'b001);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule